// File: doc/BRIEF.md
# Shared Bus-Master Request/Grant Splicer

This block lets several bus-master devices share one request/grant channel of a parallel PCI-style bus bridge. Each device drives its own active-low request and receives its own active-low grant. The bridge sees one merged active-low request and returns one active-low grant. The splicer does not arbitrate the bus. It follows the bridge's grant and steers that grant to exactly one device at a time. Parallel wiring of masters onto a shared pair is unsafe, and this block takes its place.

When the channel is idle and requests are pending, the splicer picks one device round-robin. The most recently served device has the lowest priority. That device stays the owner until it drops its request and the bridge has dropped the upstream grant. A device's grant is gated by the live upstream grant, so it falls in the same cycle the bridge withdraws it. Between two owners the merged request stays deasserted, so the bridge sees one completed handshake per device.

Top module: `busGrantSplicer`

## Requirements
- R1: Outside a release window, `upReqN` is low after a rising edge exactly when at least one bit of `devReqN` was low at that edge. This is a one-edge latency.
- R2: At most one bit of `devGntN` is low at any time.
- R3: A device's grant bit (`devGntN[i]`, bit i for device i) goes low only if that device's request was low at the edge that selected it. The grant goes to the selected device as soon as `upGntN` is low.
- R4: When several requests are pending in the idle state, the selected device is the first requesting index after the most recently granted one, counting upward and wrapping from N-1 to 0. After reset, device 0 has the highest priority.
- R5: While the owner keeps its request low, no other device is granted. This holds even if `upGntN` goes high and returns low.
- R6: When the owner's request is seen high at an edge, its grant and `upReqN` go high at that edge. `upReqN` stays high until an edge sees `upGntN` high. A new owner may be selected no earlier than the following edge.
- R7: A `devGntN` bit is low only while `upGntN` is low. It rises in the same cycle `upGntN` rises, with no clock edge in between.
- R8: While `rstN` is low, and at the first edge after reset with no requests, all of `devGntN` and `upReqN` are high.
- R9: The number of devices is the parameter `NUM_DEV`, which defaults to 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Active-low reset |
| devReqN | input | NUM_DEV | Active-low request, one per device |
| devGntN | output | NUM_DEV | Active-low grant, one per device |
| upReqN | output | 1 | Merged active-low request to the bridge |
| upGntN | input | 1 | Active-low grant from the bridge |

## Verification
`upReqN` and the choice of owner are settled one rising edge after the requests are applied. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. Grants depend on `upGntN` with no register in between, so each grant check is made 1 ns after `upGntN` changes, with no clock edge between. A release costs two edges before a waiting device can win: one edge to drop the owner, and one edge to see the upstream grant gone. The handover checks sample `upReqN` at both of those edges and again at the selecting edge.

// File: rtl/splicerPkg.sv
package splicerPkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BUSY    = 2'd1,
    ST_RELEASE = 2'd2
  } splState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setGnt;   // load one-hot grant for selIdx
    logic clrGnt;   // drop all held grants
    logic upReqOn;  // next value of merged request
  } splStrobe_t;

endpackage

// File: rtl/splicerPick.sv
module splicerPick #(
  parameter int NUM_DEV = 2,
  localparam int IW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic [NUM_DEV-1:0] reqVec,
  input  logic [IW-1:0]      lastIdx,
  output logic               anyReq,
  output logic [IW-1:0]      pickIdx
);

  always_comb begin
    int cand;
    logic found;
    found   = 1'b0;
    pickIdx = '0;
    for (int k = 1; k <= NUM_DEV; k++) begin
      cand = (int'(lastIdx) + k) % NUM_DEV;
      if (!found && reqVec[cand]) begin
        found   = 1'b1;
        pickIdx = IW'(cand);
      end
    end
    anyReq = |reqVec;
  end

endmodule

// File: rtl/splicerCtrl.sv
module splicerCtrl
  import splicerPkg::*;
#(
  parameter int NUM_DEV = 2,
  localparam int IW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] reqVec,
  input  logic               upGnt,
  output splStrobe_t         strobe,
  output logic [IW-1:0]      selIdx
);

  splState_t   state, stateNext;
  logic [IW-1:0] ownerIdx, ownerNext;
  logic [IW-1:0] lastIdx, lastNext;
  logic          anyReq;
  logic [IW-1:0] pickIdx;

  splicerPick #(.NUM_DEV(NUM_DEV)) u_pick (
    .reqVec (reqVec),
    .lastIdx(lastIdx),
    .anyReq (anyReq),
    .pickIdx(pickIdx)
  );

  always_comb begin
    stateNext = state;
    ownerNext = ownerIdx;
    lastNext  = lastIdx;
    strobe    = '0;
    selIdx    = ownerIdx;
    unique case (state)
      ST_IDLE: begin
        if (anyReq) begin
          stateNext      = ST_BUSY;
          ownerNext      = pickIdx;
          lastNext       = pickIdx;
          selIdx         = pickIdx;
          strobe.setGnt  = 1'b1;
          strobe.upReqOn = 1'b1;
        end else begin
          strobe.clrGnt  = 1'b1;
        end
      end
      ST_BUSY: begin
        if (reqVec[ownerIdx]) begin
          strobe.setGnt  = 1'b1;
          strobe.upReqOn = 1'b1;
        end else begin
          strobe.clrGnt  = 1'b1;
          stateNext      = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        strobe.clrGnt = 1'b1;
        if (!upGnt) stateNext = ST_IDLE;
      end
      default: begin
        strobe.clrGnt = 1'b1;
        stateNext     = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ownerIdx <= '0;
      lastIdx  <= IW'(NUM_DEV - 1);
    end else begin
      state    <= stateNext;
      ownerIdx <= ownerNext;
      lastIdx  <= lastNext;
    end
  end

  AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY && reqVec[ownerIdx]) |=> (state == ST_BUSY && $stable(ownerIdx))); // R5

  AST_RELEASE_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELEASE && upGnt) |=> (state == ST_RELEASE)); // R6

endmodule

// File: rtl/splicerPath.sv
module splicerPath
  import splicerPkg::*;
#(
  parameter int NUM_DEV = 2,
  localparam int IW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  splStrobe_t         strobe,
  input  logic [IW-1:0]      selIdx,
  input  logic               upGnt,
  output logic [NUM_DEV-1:0] gntQ,
  output logic [NUM_DEV-1:0] devGntN,
  output logic               upReqN
);

  logic upReqQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gntQ   <= '0;
      upReqQ <= 1'b0;
    end else begin
      upReqQ <= strobe.upReqOn;
      if (strobe.clrGnt)
        gntQ <= '0;
      else if (strobe.setGnt)
        gntQ <= NUM_DEV'(1) << selIdx;
    end
  end

  // grant reaches a device only while the bridge grant is live
  assign devGntN = ~(gntQ & {NUM_DEV{upGnt}});
  assign upReqN  = ~upReqQ;

  AST_HELD_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntQ)); // R2

endmodule

// File: rtl/busGrantSplicer.sv
module busGrantSplicer
  import splicerPkg::*;
#(
  parameter int NUM_DEV = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devReqN,
  output logic [NUM_DEV-1:0] devGntN,
  output logic               upReqN,
  input  logic               upGntN
);

  localparam int IW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  splStrobe_t         strobe;
  logic [IW-1:0]      selIdx;
  logic [NUM_DEV-1:0] reqVec;
  logic [NUM_DEV-1:0] gntQ;
  logic               upGnt;

  assign reqVec = ~devReqN;
  assign upGnt  = ~upGntN;

  splicerCtrl #(.NUM_DEV(NUM_DEV)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .reqVec(reqVec),
    .upGnt (upGnt),
    .strobe(strobe),
    .selIdx(selIdx)
  );

  splicerPath #(.NUM_DEV(NUM_DEV)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .selIdx (selIdx),
    .upGnt  (upGnt),
    .gntQ   (gntQ),
    .devGntN(devGntN),
    .upReqN (upReqN)
  );

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~devGntN)); // R2

  AST_UPREQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !upReqN |-> $past(devReqN != {NUM_DEV{1'b1}})); // R1

  AST_SWITCH_VIA_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(gntQ != '0) && gntQ != '0) |-> gntQ == $past(gntQ)); // R5

  AST_RELEASE_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    ($past(gntQ != '0) && gntQ == '0) |-> upReqN); // R6

  AST_GNT_LIVE_UP: assert property (@(posedge clk) disable iff (!rstN)
    (devGntN != {NUM_DEV{1'b1}}) |-> !upGntN); // R7

  for (genvar gi = 0; gi < NUM_DEV; gi++) begin : g_chk
    AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
      $rose(gntQ[gi]) |-> $past(!devReqN[gi])); // R3
  end

endmodule

// File: tb/busGrantSplicer_bench.sv
module busGrantSplicer_bench;

  localparam int N = 3;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] devReqN = '1;
  logic [N-1:0] devGntN;
  logic         upReqN;
  logic         upGntN = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int lastWin;

  always #2 clk = ~clk;

  busGrantSplicer #(.NUM_DEV(N)) u_busGrantSplicer (
    .clk(clk), .rstN(rstN), .devReqN(devReqN),
    .devGntN(devGntN), .upReqN(upReqN), .upGntN(upGntN)
  );

  function automatic int rrPick(int last, int mask);
    for (int k = 1; k <= N; k++) begin
      int c = (last + k) % N;
      if (mask[c]) return c;
    end
    return -1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edgeSample();
    @(posedge clk); #1;
  endtask

  task automatic trial(int mask);
    int win = rrPick(lastWin, mask);
    @(negedge clk); devReqN = ~N'(mask);
    edgeSample();
    check(upReqN == 1'b0, "R1 merged request", upReqN, 0);
    check(devGntN == '1, "R7 no grant before bridge", devGntN, 3'b111);
    @(negedge clk); upGntN = 1'b0; #1;
    check(devGntN == ~N'(1 << win), "R4 round-robin winner", devGntN, ~N'(1 << win));
    check($countones(~devGntN) <= 1, "R2 single grant", devGntN, ~N'(1 << win));
    edgeSample();
    check(devGntN == ~N'(1 << win), "R3 grant held", devGntN, ~N'(1 << win));
    @(negedge clk); devReqN[win] = 1'b1;
    edgeSample();
    check(devGntN == '1, "R6 grant dropped", devGntN, 3'b111);
    check(upReqN == 1'b1, "R6 request dropped", upReqN, 1);
    edgeSample();
    check(upReqN == 1'b1, "R6 gap while bridge grants", upReqN, 1);
    @(negedge clk); upGntN = 1'b1; devReqN = '1;
    edgeSample();
    edgeSample();
    check(upReqN == 1'b1, "R1 idle no request", upReqN, 1);
    lastWin = win;
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    lastWin = N - 1;
    edgeSample(); edgeSample();
    check(upReqN == 1'b1, "R8 reset request", upReqN, 1);
    check(devGntN == '1, "R8 reset grants", devGntN, 3'b111);
    @(negedge clk); rstN = 1'b1;
    edgeSample();
    check(upReqN == 1'b1 && devGntN == '1, "R8 after reset", {devGntN, upReqN}, 4'hF);

    // withdrawal and handover, device 0 first after reset
    @(negedge clk); devReqN = 3'b110;
    edgeSample();
    check(upReqN == 1'b0, "R1 single request", upReqN, 0);
    @(negedge clk); upGntN = 1'b0; #1;
    check(devGntN == 3'b110, "R4 device 0 first", devGntN, 3'b110);
    @(negedge clk); devReqN = 3'b100; upGntN = 1'b1; #1;
    check(devGntN == 3'b111, "R7 withdraw same cycle", devGntN, 3'b111);
    edgeSample(); edgeSample();
    check(devGntN == 3'b111, "R7 withdrawn stays off", devGntN, 3'b111);
    @(negedge clk); upGntN = 1'b0; #1;
    check(devGntN == 3'b110, "R5 owner kept", devGntN, 3'b110);
    @(negedge clk); devReqN = 3'b101;
    edgeSample();
    check(devGntN == 3'b111 && upReqN == 1'b1, "R6 release", {devGntN, upReqN}, 4'hF);
    @(negedge clk); upGntN = 1'b1;
    edgeSample();
    check(upReqN == 1'b1, "R6 one clock gap", upReqN, 1);
    edgeSample();
    check(upReqN == 1'b0, "R6 next owner request", upReqN, 0);
    @(negedge clk); upGntN = 1'b0; #1;
    check(devGntN == 3'b101, "R6 handover to device 1", devGntN, 3'b101);
    check($countones(~devGntN) == 1, "R2 handover single", devGntN, 3'b101);
    @(negedge clk); devReqN = '1;
    edgeSample();
    @(negedge clk); upGntN = 1'b1;
    edgeSample(); edgeSample();
    lastWin = 1;

    // sweep: every request pattern, twice so the pointer moves through all values
    for (int rep = 0; rep < 2; rep++)
      for (int m = 1; m < (1 << N); m++)
        trial(m);

    check(N == 3, "R9 device count", N, 3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule